// File: doc/BRIEF.md
# Two-Port Pin Controller with Per-Pin Peripheral Selection

This block sits between a chip's pin pads and a few internal peripherals. Port A is an input port. Its pins pass through a two-stage synchronizer, and software can read them over a small register bus. Two select bits decide whether the UART's transmit-enable input and receive-data input see the synchronized pin level or a fixed idle level. When unselected, transmit-enable is held low and receive-data is held high.

Port B is a twelve-pin output port. A select bit for each pin chooses between a software-written data bit and a signal from a printer, scanner or DMA engine. One enable bit drives all twelve output enables together. After reset every pin is in high impedance. The pads resolve the tristate from `pb_oe_o`.

The register bus has one address, a write strobe and write data. Read data is combinational from the address. Register map, as a word offset:
- 0: Port A input, read-only, bits 3:0.
- 1: Port A select, bits 1:0.
- 2: Port B data out, bits 11:0.
- 3: Port B select, bits 11:0.
- 4: Port B enable, bit 0.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, the select registers, the data-out register and the enable bit all read 0. `pb_oe_o` is all zero, `uart_txen_o` is 0 and `uart_rxd_o` is 1.
- R2: Address 0 returns the Port A pin levels in bits 3:0. A pin change becomes visible after two rising clock edges. Writes to address 0 have no effect.
- R3: Port A select bit 0 controls `uart_txen_o`. When the bit is 0, the output is 0. When the bit is 1, the output follows synchronized pin 0.
- R4: Port A select bit 1 controls `uart_rxd_o`. When the bit is 0, the output is 1. When the bit is 1, the output follows synchronized pin 1.
- R5: For each Port B pin whose select bit is 0, `pb_out_o` carries the matching data-out register bit.
- R6: For each Port B pin whose select bit is 1, `pb_out_o` carries the matching `periph_b_i` bit.
- R7: When enable bit 0 is 1, all twelve bits of `pb_oe_o` are 1. When it is 0, all twelve bits are 0.
- R8: Reserved register bits read 0, and writing 1 to them has no effect. This covers bits above 1 at address 1, above 11 at addresses 2 and 3, above 0 at address 4, and above 3 at address 0.
- R9: Writable registers read back the last value written to their implemented bits. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | 3 | Register word address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| pa_pins_i | input | 4 | Asynchronous Port A pin levels |
| uart_txen_o | output | 1 | UART transmit-enable input, gated |
| uart_rxd_o | output | 1 | UART receive-data input, gated |
| periph_b_i | input | 12 | Peripheral signals for the Port B pins |
| pb_out_o | output | 12 | Port B pin output values |
| pb_oe_o | output | 12 | Port B output enables (0 = high impedance) |

## Verification
The embedded assertions check the following on every cycle:
- the forced idle levels on the two UART inputs while their select bits are clear;
- all-port and all-peripheral routing on Port B;
- that the twelve output enables always move together and follow the enable bit;
- that reserved read-data bits stay zero.

Only the bench scenarios show certain other behaviours:
- the two-edge input latency;
- mixed per-pin selection patterns;
- readback of written values;
- that writes to the read-only and reserved bits are discarded;
- the reset values seen through the bus.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int PA_PINS = 4;
    localparam int PA_SELS = 2;
    localparam int PB_PINS = 12;

    typedef enum logic [ADDR_W-1:0] {
        REG_PA_IN  = 3'd0,
        REG_PA_SEL = 3'd1,
        REG_PB_OUT = 3'd2,
        REG_PB_SEL = 3'd3,
        REG_PB_EN  = 3'd4
    } reg_addr_e;

    localparam int PA_TXEN_BIT = 0;
    localparam int PA_RXD_BIT  = 1;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int PAW = PA_PINS,
    parameter int PSW = PA_SELS,
    parameter int PBW = PB_PINS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr_i,
    input  logic           wr_i,
    input  logic [DW-1:0]  wdata_i,
    input  logic [PAW-1:0] pa_sync_i,
    output logic [DW-1:0]  rdata_o,
    output logic [PSW-1:0] pa_sel_o,
    output logic [PBW-1:0] pb_dout_o,
    output logic [PBW-1:0] pb_sel_o,
    output logic           pb_en_o
);
    typedef struct packed {
        logic [PSW-1:0] pa_sel;
        logic [PBW-1:0] pb_dout;
        logic [PBW-1:0] pb_sel;
        logic           pb_en;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            case (addr_i)
                REG_PA_SEL: regs_d.pa_sel  = wdata_i[PSW-1:0];
                REG_PB_OUT: regs_d.pb_dout = wdata_i[PBW-1:0];
                REG_PB_SEL: regs_d.pb_sel  = wdata_i[PBW-1:0];
                REG_PB_EN:  regs_d.pb_en   = wdata_i[0];
                default:    regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            REG_PA_IN:  rdata_o[PAW-1:0] = pa_sync_i;
            REG_PA_SEL: rdata_o[PSW-1:0] = regs_q.pa_sel;
            REG_PB_OUT: rdata_o[PBW-1:0] = regs_q.pb_dout;
            REG_PB_SEL: rdata_o[PBW-1:0] = regs_q.pb_sel;
            REG_PB_EN:  rdata_o[0]       = regs_q.pb_en;
            default:    rdata_o = '0;
        endcase
    end

    assign pa_sel_o  = regs_q.pa_sel;
    assign pb_dout_o = regs_q.pb_dout;
    assign pb_sel_o  = regs_q.pb_sel;
    assign pb_en_o   = regs_q.pb_en;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DW-1:PBW] == '0); // R8
    AST_PB_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i || addr_i != REG_PB_EN) |=> $stable(pb_en_o)); // R9
endmodule

// File: rtl/gpio_port_a.sv
module gpio_port_a
    import gpio_pkg::*;
#(
    parameter int PAW = PA_PINS,
    parameter int PSW = PA_SELS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PAW-1:0] pins_i,
    input  logic [PSW-1:0] sel_i,
    output logic [PAW-1:0] sync_o,
    output logic           txen_o,
    output logic           rxd_o
);
    typedef struct packed {
        logic [PAW-1:0] stage1;
        logic [PAW-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.stage1 = pins_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_o = sync_q.stage2;
    assign txen_o = sel_i[PA_TXEN_BIT] ? sync_q.stage2[PA_TXEN_BIT] : 1'b0;
    assign rxd_o  = sel_i[PA_RXD_BIT]  ? sync_q.stage2[PA_RXD_BIT]  : 1'b1;
endmodule

// File: rtl/gpio_port_b.sv
module gpio_port_b
    import gpio_pkg::*;
#(
    parameter int PBW = PB_PINS
) (
    input  logic [PBW-1:0] dout_i,
    input  logic [PBW-1:0] sel_i,
    input  logic [PBW-1:0] periph_i,
    input  logic           en_i,
    output logic [PBW-1:0] pin_o,
    output logic [PBW-1:0] oe_o
);
    for (genvar i = 0; i < PBW; i++) begin : g_pin
        assign pin_o[i] = sel_i[i] ? periph_i[i] : dout_i[i];
        assign oe_o[i]  = en_i;
    end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
    import gpio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_wr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    input  logic [PA_PINS-1:0]  pa_pins_i,
    output logic                uart_txen_o,
    output logic                uart_rxd_o,
    input  logic [PB_PINS-1:0]  periph_b_i,
    output logic [PB_PINS-1:0]  pb_out_o,
    output logic [PB_PINS-1:0]  pb_oe_o
);
    logic [PA_PINS-1:0] pa_sync;
    logic [PA_SELS-1:0] pa_sel;
    logic [PB_PINS-1:0] pb_dout;
    logic [PB_PINS-1:0] pb_sel;
    logic               pb_en;

    gpio_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr_i),
        .wr_i      (bus_wr_i),
        .wdata_i   (bus_wdata_i),
        .pa_sync_i (pa_sync),
        .rdata_o   (bus_rdata_o),
        .pa_sel_o  (pa_sel),
        .pb_dout_o (pb_dout),
        .pb_sel_o  (pb_sel),
        .pb_en_o   (pb_en)
    );

    gpio_port_a u_port_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pa_pins_i),
        .sel_i  (pa_sel),
        .sync_o (pa_sync),
        .txen_o (uart_txen_o),
        .rxd_o  (uart_rxd_o)
    );

    gpio_port_b u_port_b (
        .dout_i   (pb_dout),
        .sel_i    (pb_sel),
        .periph_i (periph_b_i),
        .en_i     (pb_en),
        .pin_o    (pb_out_o),
        .oe_o     (pb_oe_o)
    );

    AST_TXEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pa_sel[PA_TXEN_BIT] |-> !uart_txen_o); // R3
    AST_RXD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pa_sel[PA_RXD_BIT] |-> uart_rxd_o); // R4
    AST_PB_ALL_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_sel == '0) |-> (pb_out_o == pb_dout)); // R5
    AST_PB_ALL_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_sel == '1) |-> (pb_out_o == periph_b_i)); // R6
    AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pb_oe_o) == 0) || ($countones(pb_oe_o) == PB_PINS)); // R7
    AST_OE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == REG_PB_EN) |=> (pb_oe_o[0] == $past(bus_wdata_i[0]))); // R7
endmodule

// File: tb/gpio_mux_port_bench.sv
module gpio_mux_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  pa_pins = '0;
    logic        txen, rxd;
    logic [11:0] periph = '0;
    logic [11:0] pb_out, pb_oe;
    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio_mux_port u_gpio_mux_port (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pa_pins_i(pa_pins),
        .uart_txen_o(txen), .uart_rxd_o(rxd), .periph_b_i(periph),
        .pb_out_o(pb_out), .pb_oe_o(pb_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 1; a < 5; a++) begin
            rd_reg(3'(a), v);
            chk("R1 reg reset", 32'(v), 32'h0);
        end
        chk("R1 oe reset", 32'(pb_oe), 32'h0);
        chk("R1 txen reset", 32'(txen), 32'h0);
        chk("R1 rxd reset", 32'(rxd), 32'h1);
    endtask

    task automatic t_readback;
        logic [15:0] v;
        wr_reg(3'd2, 16'h0A5C); rd_reg(3'd2, v); chk("R9 dout rb", 32'(v), 32'h0A5C);
        wr_reg(3'd3, 16'h0123); rd_reg(3'd3, v); chk("R9 sel rb", 32'(v), 32'h0123);
        wr_reg(3'd1, 16'h0002); rd_reg(3'd1, v); chk("R9 pasel rb", 32'(v), 32'h0002);
        for (int a = 5; a < 8; a++) begin
            wr_reg(3'(a), 16'hFFFF); rd_reg(3'(a), v);
            chk("R9 unmapped", 32'(v), 32'h0);
        end
    endtask

    task automatic t_reserved;
        logic [15:0] v;
        wr_reg(3'd1, 16'hFFFC); rd_reg(3'd1, v); chk("R8 pasel rsvd", 32'(v), 32'h0);
        wr_reg(3'd2, 16'hF000); rd_reg(3'd2, v); chk("R8 dout rsvd", 32'(v), 32'h0);
        wr_reg(3'd3, 16'hFFFF); rd_reg(3'd3, v); chk("R8 sel rsvd", 32'(v), 32'h0FFF);
        wr_reg(3'd4, 16'hFFFE); rd_reg(3'd4, v); chk("R8 en rsvd", 32'(v), 32'h0);
        chk("R8 en rsvd oe", 32'(pb_oe), 32'h0);
        wr_reg(3'd3, 16'h0000);
    endtask

    task automatic t_port_a_read;
        logic [15:0] v;
        @(negedge clk); pa_pins = 4'hB;
        @(negedge clk); addr = 3'd0; #1 chk("R2 not yet", 32'(rdata), 32'h0);
        @(negedge clk); #1 chk("R2 two edges", 32'(rdata), 32'hB);
        wr_reg(3'd0, 16'hFFF4); rd_reg(3'd0, v); chk("R2 write ignored", 32'(v), 32'hB);
        @(negedge clk); pa_pins = 4'h6;
        repeat (2) @(negedge clk);
        rd_reg(3'd0, v); chk("R2 new value", 32'(v), 32'h6);
    endtask

    task automatic t_uart;
        wr_reg(3'd1, 16'h0000);
        @(negedge clk); pa_pins = 4'h1; repeat (2) @(negedge clk);
        chk("R3 forced low", 32'(txen), 32'h0);
        chk("R4 forced high", 32'(rxd), 32'h1);
        wr_reg(3'd1, 16'h0003);
        chk("R3 follows 1", 32'(txen), 32'h1);
        chk("R4 follows 0", 32'(rxd), 32'h0);
        @(negedge clk); pa_pins = 4'h2; repeat (2) @(negedge clk);
        chk("R3 follows 0", 32'(txen), 32'h0);
        chk("R4 follows 1", 32'(rxd), 32'h1);
        wr_reg(3'd1, 16'h0001);
        chk("R4 reforced", 32'(rxd), 32'h1);
        @(negedge clk); pa_pins = 4'h0; repeat (2) @(negedge clk);
        chk("R4 reforced low pin", 32'(rxd), 32'h1);
    endtask

    task automatic t_port_b;
        wr_reg(3'd2, 16'h0C3A);
        wr_reg(3'd3, 16'h0000);
        @(negedge clk); periph = 12'h5F0; #1;
        chk("R5 all port", 32'(pb_out), 32'h0C3A);
        wr_reg(3'd3, 16'h0FFF); #1;
        chk("R6 all periph", 32'(pb_out), 32'h05F0);
        wr_reg(3'd3, 16'h00FF); #1;
        chk("R5 R6 mixed", 32'(pb_out), 32'h0CF0);
        @(negedge clk); periph = 12'hA0F; #1;
        chk("R6 periph change", 32'(pb_out), 32'h0C0F);
    endtask

    task automatic t_enable;
        wr_reg(3'd4, 16'h0001); #1;
        chk("R7 enabled", 32'(pb_oe), 32'h0FFF);
        wr_reg(3'd4, 16'h0000); #1;
        chk("R7 disabled", 32'(pb_oe), 32'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_reset;
        t_readback;
        t_reserved;
        t_port_a_read;
        t_uart;
        t_port_b;
        t_enable;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule